// File: doc/BRIEF.md
# Receive Frame Scatter with Check-Sequence Append

This block sits behind the address filter of an Ethernet receive path. It takes one accepted frame at a time as a byte stream and spreads it over a chain of receive buffers whose sizes come from a separate descriptor stream. Frames that are too short are dropped. Frames shorter than 60 bytes are padded with zeros to 60 bytes. After the stored data the block appends the 4-byte frame check sequence, and this sequence may be split across two buffers.

The block does not address memory itself. Every stored byte leaves on a write port, tagged with the index of the buffer within the frame and the byte offset inside that buffer. When a buffer closes, the block emits a 16-bit actual-count word for it. When the frame is finished, it emits a status word, or a drop pulse if the frame was too short. Descriptor fetching and the memory writes themselves belong to the surrounding logic.

Top module: `rx_scatter`

## Requirements
- R1: A frame whose length L is below max(min_len, 5) is dropped. The drop output pulses once and no status word is produced. The frame's last byte is not written, and the buffer that is open at that moment gets no count word.
- R2: When L < 60, bytes L..59 are stored as zeros after the frame bytes. The stored length is max(L, 60) + 4.
- R3: The last four stored bytes are the CRC-32 of the L frame bytes only (reflected polynomial 0xEDB88320, initial value all ones, result complemented). Bits 31:24 are stored first and bits 7:0 last.
- R4: A descriptor word gives the buffer capacity in bits 13:0 and marks the last buffer of the chain with bit 15. Bit 14 is ignored. A buffer of capacity zero closes at once with count word 0x4000.
- R5: Buffers are filled in descriptor order starting at offset 0. Each buffer takes the smaller of its capacity and the bytes still to store. Buffer indices count from 0 within the frame.
- R6: Each closed buffer produces a count word. Bits 13:0 hold the bytes written, bit 14 is always 1, and bit 15 is 1 only on the buffer that holds the final check-sequence byte.
- R7: A completed frame produces one status word. Bit 15 is 1, bit 13 is 1 when there was no overflow, bit 0 is the broadcast/multicast flag captured with the start byte, and every other bit is 0.
- R8: If the buffer marked last closes before all stored bytes are placed, the remaining bytes are discarded. Input is still consumed up to the end byte, and the status reports st_ovf = 1 with bit 13 clear.
- R9: After reset, no write, count word, status or drop is reported.
- R10: While a buffer has room, one byte is written per cycle with no gaps, across the data, padding and check-sequence phases. Input is stalled during each count-word cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_len | input | 8 | Configured minimum frame length (floor 5) |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted this cycle when valid |
| in_data | input | 8 | Frame byte |
| in_sof | input | 1 | First byte of frame |
| in_eof | input | 1 | Last byte of frame |
| in_bc | input | 1 | Broadcast/multicast flag, sampled with the first byte |
| bd_valid | input | 1 | Buffer descriptor valid |
| bd_ready | output | 1 | Descriptor accepted this cycle when valid |
| bd_size | input | 16 | Descriptor word: capacity 13:0, last flag 15 |
| wr_valid | output | 1 | Byte write strobe |
| wr_buf | output | IDX_W | Buffer index within the frame |
| wr_off | output | 14 | Byte offset in the buffer |
| wr_data | output | 8 | Byte to store |
| cw_valid | output | 1 | Count word strobe |
| cw_buf | output | IDX_W | Buffer index of the count word |
| cw_word | output | 16 | Count word |
| st_valid | output | 1 | Frame status strobe |
| st_word | output | 16 | Frame status word |
| st_ovf | output | 1 | Buffer chain overflow, valid with st_valid |
| drop | output | 1 | Short frame dropped (pulse) |

## Verification
The bench uses the default parameters: a 4-bit buffer index, 16-bit length counters, a padding target of 60 and a minimum floor of 5. It sweeps every frame length from 1 to 70 against five buffer chains and two minimum settings. One chain is a single large buffer. One is a run of 16-byte buffers. One mixes capacity-zero buffers with a descriptor that has bit 14 set. One is too short and overflows. One makes the check sequence straddle a buffer boundary. Together these reach every transition between the data, padding and check-sequence phases and the drop boundary at lengths 4/5 and 63/64. The expected bytes, count words and status are computed arithmetically from the frame pattern.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DATA, S_PAD, S_CRC, S_CLOSE, S_STAT, S_DISC
  } rxs_state_t;

  localparam logic [31:0] FCS_POLY = 32'hEDB88320;

  function automatic logic [31:0] fcs_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ FCS_POLY;
    end
    return r;
  endfunction

endpackage

// File: rtl/rxs_fcs.sv
module rxs_fcs (
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] fcs
);
  import rxs_pkg::*;

  logic [31:0] acc;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '1;
    else if (en)    acc <= fcs_step(acc, din);
  end

  assign fcs = ~acc;
endmodule

// File: rtl/rxs_slot.sv
module rxs_slot #(
  parameter int CW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] size_in,
  input  logic          last_in,
  input  logic          adv,
  input  logic          rel,
  output logic          have,
  output logic [CW-1:0] size,
  output logic [CW-1:0] off,
  output logic          last
);
  always_ff @(posedge clk) begin
    if (rst) begin
      have <= 1'b0;
      size <= '0;
      off  <= '0;
      last <= 1'b0;
    end else if (load) begin
      have <= 1'b1;
      size <= size_in;
      last <= last_in;
      off  <= '0;
    end else begin
      if (adv) off  <= off + 1'b1;
      if (rel) have <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_scatter.sv
module rx_scatter #(
  parameter int IDX_W     = 4,
  parameter int LEN_W     = 16,
  parameter int PAD_LEN   = 60,
  parameter int MIN_FLOOR = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       min_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_bc,
  input  logic             bd_valid,
  output logic             bd_ready,
  input  logic [15:0]      bd_size,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_buf,
  output logic [13:0]      wr_off,
  output logic [7:0]       wr_data,
  output logic             cw_valid,
  output logic [IDX_W-1:0] cw_buf,
  output logic [15:0]      cw_word,
  output logic             st_valid,
  output logic [15:0]      st_word,
  output logic             st_ovf,
  output logic             drop
);
  import rxs_pkg::*;

  localparam int CW = 14;
  localparam logic [LEN_W-1:0] PAD_L  = LEN_W'(PAD_LEN);
  localparam logic [7:0]       FLOOR8 = 8'(MIN_FLOOR);

  rxs_state_t st, ret_st;
  logic [LEN_W-1:0] flen, scnt, eff_min, len_n;
  logic [1:0]       fcs_i;
  logic             bc_q, ovf_q, chain_end, close_eof;
  logic [IDX_W-1:0] bidx;

  logic          have, blast, s_load, s_adv, s_rel;
  logic [CW-1:0] bsize, boff;
  logic [CW:0]   off_inc;
  logic          full_n, wr_st, in_fire, short_eof, emit, acq_ovf, acq_zero;
  logic [31:0]   f_val;
  logic [7:0]    fcs_byte, emit_data;
  logic [4:0]    fcs_sh;
  logic          unused_bits;

  assign unused_bits = bd_size[14];

  assign eff_min   = (min_len < FLOOR8) ? LEN_W'(FLOOR8) : LEN_W'(min_len);
  assign wr_st     = (st == S_DATA) || (st == S_PAD) || (st == S_CRC);
  assign bd_ready  = wr_st && !have && !chain_end;
  assign s_load    = bd_ready && bd_valid;
  assign acq_zero  = s_load && (bd_size[CW-1:0] == '0);
  assign acq_ovf   = wr_st && !have && chain_end;
  assign in_ready  = ((st == S_DATA) && have) || (st == S_DISC);
  assign in_fire   = in_valid && in_ready;
  assign len_n     = flen + 1'b1;
  assign short_eof = in_fire && in_eof && (len_n < eff_min);
  assign off_inc   = {1'b0, boff} + 1'b1;
  assign full_n    = (off_inc == {1'b0, bsize});
  assign fcs_sh    = {~fcs_i, 3'b000};
  assign fcs_byte  = 8'(f_val >> fcs_sh);

  always_comb begin
    emit      = 1'b0;
    emit_data = 8'h00;
    case (st)
      S_DATA: begin emit = in_fire && !short_eof; emit_data = in_data; end
      S_PAD:  begin emit = have;                  emit_data = 8'h00;   end
      S_CRC:  begin emit = have;                  emit_data = fcs_byte; end
      default: ;
    endcase
  end

  assign s_adv = emit;
  assign s_rel = (st == S_CLOSE) || ((st == S_DATA) && short_eof);

  rxs_slot #(.CW(CW)) u_slot (
    .clk(clk), .rst(rst), .load(s_load), .size_in(bd_size[CW-1:0]),
    .last_in(bd_size[15]), .adv(s_adv), .rel(s_rel),
    .have(have), .size(bsize), .off(boff), .last(blast)
  );

  rxs_fcs u_fcs (
    .clk(clk), .rst(rst), .clr((st == S_IDLE) && in_valid && in_sof),
    .en((st == S_DATA) && in_fire), .din(in_data), .fcs(f_val)
  );

  always_ff @(posedge clk) begin
    wr_valid <= 1'b0;
    cw_valid <= 1'b0;
    st_valid <= 1'b0;
    drop     <= 1'b0;
    if (rst) begin
      st <= S_IDLE;  ret_st <= S_IDLE;
      flen <= '0;  scnt <= '0;  fcs_i <= '0;  bidx <= '0;
      bc_q <= 1'b0;  ovf_q <= 1'b0;  chain_end <= 1'b0;  close_eof <= 1'b0;
      wr_buf <= '0;  wr_off <= '0;  wr_data <= '0;
      cw_buf <= '0;  cw_word <= '0;  st_word <= '0;  st_ovf <= 1'b0;
    end else begin
      if (emit) begin
        wr_valid <= 1'b1;
        wr_buf   <= bidx;
        wr_off   <= boff;
        wr_data  <= emit_data;
      end
      if (acq_zero) begin
        st <= S_CLOSE;  ret_st <= st;  close_eof <= 1'b0;
      end else if (acq_ovf) begin
        ovf_q <= 1'b1;
        st    <= (st == S_DATA) ? S_DISC : S_STAT;
      end else begin
        case (st)
          S_IDLE: if (in_valid && in_sof) begin
            st <= S_DATA;  flen <= '0;  scnt <= '0;  fcs_i <= '0;
            bidx <= '0;  bc_q <= in_bc;  ovf_q <= 1'b0;  chain_end <= 1'b0;
          end
          S_DATA: if (in_fire) begin
            flen <= len_n;
            if (short_eof) begin
              drop <= 1'b1;
              st   <= S_IDLE;
            end else begin
              rxs_state_t nx;
              nx   = in_eof ? ((len_n < PAD_L) ? S_PAD : S_CRC) : S_DATA;
              scnt <= scnt + 1'b1;
              if (full_n) begin
                st <= S_CLOSE;  ret_st <= nx;  close_eof <= 1'b0;
              end else st <= nx;
            end
          end
          S_PAD: if (have) begin
            rxs_state_t nx;
            nx   = (scnt + 1'b1 == PAD_L) ? S_CRC : S_PAD;
            scnt <= scnt + 1'b1;
            if (full_n) begin
              st <= S_CLOSE;  ret_st <= nx;  close_eof <= 1'b0;
            end else st <= nx;
          end
          S_CRC: if (have) begin
            fcs_i <= fcs_i + 2'd1;
            if (full_n || fcs_i == 2'd3) begin
              st        <= S_CLOSE;
              ret_st    <= (fcs_i == 2'd3) ? S_STAT : S_CRC;
              close_eof <= (fcs_i == 2'd3);
            end
          end
          S_CLOSE: begin
            cw_valid <= 1'b1;
            cw_buf   <= bidx;
            cw_word  <= {close_eof, 1'b1, boff};
            bidx     <= bidx + 1'b1;
            if (blast) chain_end <= 1'b1;
            st <= ret_st;
          end
          S_DISC: if (in_fire) begin
            flen <= len_n;
            if (in_eof) begin
              if (len_n < eff_min) begin
                drop <= 1'b1;
                st   <= S_IDLE;
              end else st <= S_STAT;
            end
          end
          S_STAT: begin
            st_valid <= 1'b1;
            st_word  <= {1'b1, 1'b0, !ovf_q, 12'b0, bc_q};
            st_ovf   <= ovf_q;
            st       <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_scatter_chk.sv
module rx_scatter_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_buf,
  input logic [13:0]      wr_off,
  input logic             cw_valid,
  input logic [15:0]      cw_word,
  input logic             st_valid,
  input logic [15:0]      st_word,
  input logic             st_ovf,
  input logic             drop
);
  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wr_valid && !cw_valid && !st_valid && !drop));

  p_drop_alone_r1: assert property (@(posedge clk) disable iff (rst)
    drop |-> (!st_valid && !wr_valid));

  p_off_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && $past(wr_valid) && wr_buf == $past(wr_buf)) |-> (wr_off == $past(wr_off) + 14'd1));

  p_cw_fill_r6: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> (cw_word[14] && !wr_valid));

  p_status_form_r7: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_word[15] && !st_word[14] && st_word[12:1] == 12'd0));

  p_ovf_flag_r8: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_word[13] == !st_ovf));

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    cw_valid |-> !$past(in_ready));
endmodule

bind rx_scatter rx_scatter_chk #(.IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .wr_valid(wr_valid),
  .wr_buf(wr_buf), .wr_off(wr_off), .cw_valid(cw_valid), .cw_word(cw_word),
  .st_valid(st_valid), .st_word(st_word), .st_ovf(st_ovf), .drop(drop)
);

// File: tb/test_rx_scatter.sv
`timescale 1ns/1ps
module test_rx_scatter;
  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] min_len = 8'd0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_bc = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic bd_valid = 1'b0;
  logic [15:0] bd_size = 16'd0;
  logic in_ready, bd_ready, wr_valid, cw_valid, st_valid, st_ovf, drop;
  logic [3:0] wr_buf, cw_buf;
  logic [13:0] wr_off;
  logic [7:0] wr_data;
  logic [15:0] cw_word, st_word;

  rx_scatter i_rx_scatter (.*);

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  byte unsigned fr[0:255];
  int fr_len = 0, fr_ptr = 0, bd_n = 0, bd_ptr = 0;
  int bd[0:15];
  bit run = 0, fire_in = 0, fire_bd = 0;
  int c_len, c_cfg, c_min;

  int g_w[$], g_wt[$], g_c[$];
  int g_st = 0, g_ov = 0, g_stn = 0, g_drop = 0;
  int e_w[$], e_c[$];
  int e_st, e_ov, e_drop, e_n;

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fire_in) fr_ptr <= fr_ptr + 1;
    if (fire_bd) bd_ptr <= bd_ptr + 1;
    if (cyc > 190000) begin
      total++; bad++;
      $display("FAIL watchdog R10: got cyc=%0d exp below 190000", cyc);
      finish_up();
    end
  end

  always @(negedge clk) begin
    fire_in = 0; fire_bd = 0;
    in_valid = run && (fr_ptr < fr_len);
    in_data  = fr[fr_ptr[7:0]];
    in_sof   = (fr_ptr == 0);
    in_eof   = (fr_ptr == fr_len - 1);
    bd_valid = run && (bd_ptr < bd_n);
    bd_size  = 16'(bd[bd_ptr[3:0]]);
    if (wr_valid) begin g_w.push_back({4'd0, wr_buf, 2'd0, wr_off, wr_data}); g_wt.push_back(cyc); end
    if (cw_valid) g_c.push_back({12'd0, cw_buf, cw_word});
    if (st_valid) begin g_st = st_word; g_ov = st_ovf; g_stn++; end
    if (drop) g_drop++;
    #1;
    fire_in = in_valid && in_ready;
    fire_bd = bd_valid && bd_ready;
  end

  task automatic chk(input bit ok, input string tag, input int got, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s len=%0d cfg=%0d min=%0d: got %0h exp %0h", tag, c_len, c_cfg, c_min, got, exp);
    end
  endtask

  function automatic int bench_crc(input int n);
    int unsigned c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ 32'(fr[k]);
      for (int b = 0; b < 8; b++) c = (c >> 1) ^ ((c & 1) != 0 ? 32'hEDB88320 : 32'h0);
    end
    return int'(~c);
  endfunction

  task automatic model(input int L, input int minl, input bit bc);
    int eff, n, m, p, idx, off, sz, fcs, dat, d;
    bit have, last, ce, ovf, shrt, fin;
    eff = (minl < 5) ? 5 : minl;
    shrt = (L < eff);
    m = (L < 60) ? 60 : L;
    n = m + 4;
    e_n = n;
    fcs = bench_crc(L);
    e_w.delete(); e_c.delete();
    have = 0; last = 0; ce = 0; ovf = 0; p = 0; idx = 0; off = 0; sz = 0;
    for (int k = 0; k < n; k++) begin
      while (!have && !ovf) begin
        if (ce || p >= bd_n) ovf = 1;
        else begin
          d = bd[p]; p++;
          sz = d & 16'h3FFF; last = d[15];
          if (sz == 0) begin
            e_c.push_back(((idx & 15) << 16) | 16'h4000); idx++;
            if (last) ce = 1;
          end else begin have = 1; off = 0; end
        end
      end
      if (ovf) break;
      if (shrt && k == L - 1) break;
      if (k < L) dat = fr[k];
      else if (k < m) dat = 0;
      else dat = (fcs >> (8 * (3 - (k - m)))) & 255;
      e_w.push_back(((idx & 15) << 24) | (off << 8) | dat);
      off++;
      fin = (k == n - 1);
      if (off == sz || fin) begin
        e_c.push_back(((idx & 15) << 16) | (fin ? 16'h8000 : 0) | 16'h4000 | off);
        idx++; have = 0;
        if (last) ce = 1;
      end
    end
    e_drop = shrt;
    e_ov = ovf;
    e_st = 16'h8000 | (ovf ? 0 : 16'h2000) | bc;
  endtask

  task automatic load_cfg(input int cfg);
    case (cfg)
      0: begin bd[0] = 16'h8000 | 2000; bd_n = 1; end
      1: begin for (int i = 0; i < 6; i++) bd[i] = 16; bd[6] = 16'h8000 | 100; bd_n = 7; end
      2: begin bd[0] = 16'h4000 | 7; bd[1] = 0; bd[2] = 13; bd[3] = 16'h8000 | 200; bd_n = 4; end
      3: begin bd[0] = 10; bd[1] = 16'h8000 | 20; bd_n = 2; end
      default: begin bd[0] = 62; bd[1] = 16'h8000 | 3; bd_n = 2; end
    endcase
  endtask

  task automatic run_frame(input int L, input int cfg, input int minl, input bit bc);
    int lim, i;
    bit ok;
    c_len = L; c_cfg = cfg; c_min = minl;
    for (int k = 0; k < L; k++) fr[k] = 8'((k * 37 + L * 11 + cfg * 5 + 3) & 255);
    load_cfg(cfg);
    min_len = 8'(minl);
    in_bc = bc;
    g_w.delete(); g_wt.delete(); g_c.delete();
    g_stn = 0; g_drop = 0; g_st = 0; g_ov = 0;
    fr_len = L; fr_ptr = 0; bd_ptr = 0;
    model(L, minl, bc);
    run = 1;
    lim = 0;
    while (g_stn + g_drop == 0 && lim < 1000) begin @(negedge clk); lim++; end
    repeat (3) @(negedge clk);
    run = 0;
    @(negedge clk);
    // R2 R3 R5: every stored byte, buffer index and offset
    if (g_w.size() != e_w.size()) chk(0, "R2/R3/R5 write count", g_w.size(), e_w.size());
    else begin
      ok = 1; i = 0;
      for (int k = 0; k < e_w.size(); k++) if (ok && g_w[k] != e_w[k]) begin ok = 0; i = k; end
      chk(ok, "R2/R3/R5 write", ok ? 0 : g_w[i], ok ? 0 : e_w[i]);
    end
    // R4 R6: count words
    if (g_c.size() != e_c.size()) chk(0, "R4/R6 count-word count", g_c.size(), e_c.size());
    else begin
      ok = 1; i = 0;
      for (int k = 0; k < e_c.size(); k++) if (ok && g_c[k] != e_c[k]) begin ok = 0; i = k; end
      chk(ok, "R4/R6 count word", ok ? 0 : g_c[i], ok ? 0 : e_c[i]);
    end
    if (e_drop) begin
      chk(g_drop == 1 && g_stn == 0, "R1 drop", g_drop * 16 + g_stn, 16);
    end else begin
      chk(g_drop == 0 && g_stn == 1 && g_st == e_st, "R7 status", g_st, e_st);
      chk(g_ov == e_ov, "R8 overflow", g_ov, e_ov);
      if (cfg == 0 && g_wt.size() == e_n)
        chk(g_wt[e_n - 1] - g_wt[0] == e_n - 1, "R10 back-to-back", g_wt[e_n - 1] - g_wt[0], e_n - 1);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet after reset
    chk(!wr_valid && !cw_valid && !st_valid && !drop, "R9 reset outputs",
        {wr_valid, cw_valid, st_valid, drop}, 0);
    chk(!in_ready && !bd_ready, "R9 idle handshakes", {in_ready, bd_ready}, 0);
    for (int mi = 0; mi < 2; mi++)
      for (int cfg = 0; cfg < 5; cfg++)
        for (int L = 1; L <= 70; L++)
          run_frame(L, cfg, mi == 0 ? 0 : 64, 1'((L + cfg) & 1));
    finish_up();
  end
endmodule